// File: doc/BRIEF.md
# Interrupt distributor register bank

This block stores the per-line state of a small interrupt controller and makes it reachable over a plain 32-bit register bus. For every interrupt line it keeps an enable bit, a pending bit, an active bit, an 8-bit priority, an 8-bit processor target and a 2-bit trigger setting. It also keeps a global distributor enable and a read-only type word. A downstream selector reads the enable, pending, priority and target vectors from the output ports and picks the next interrupt to deliver.

Peripheral lines enter as one-cycle pulses that mark their interrupt pending. When a processor takes an interrupt, it returns an acknowledge strobe with the interrupt ID, and this moves the interrupt from pending to active. A later end-of-interrupt strobe clears the active bit. The line count and processor count are parameters, 64 and 4 by default. Every bus access finishes with a ready pulse in the next cycle.

Top module: `irq_dist_regs`

## Requirements
- R1: Offset 0x000 holds the global enable in bit 0. A write stores wdata[0], it drives `dist_en_o`, and a read returns it in bit 0.
- R2: Offset 0x004 reads as ((NUM_CPUS-1) << 5) | (NUM_LINES/32 - 1). With the defaults this is 0x61.
- R3: Words at 0x100+4k set enable bits and words at 0x180+4k clear them. Word k covers IDs 32k..32k+31, with ID 32k+j in bit j. A 1 in wdata sets or clears the bit, and a 0 changes nothing. A read of either window returns the current enable word.
- R4: Words at 0x200+4k set pending bits and words at 0x280+4k clear them, using the same write-one rule and bit layout as R3. A read of either window returns the current pending word.
- R5: Writes to the pending windows never change the pending bits of IDs 0 to 15.
- R6: Words at 0x300+4k read the active bits in the R3 layout.
- R7: Priorities are one byte per ID starting at 0x400. ID 4k+b sits in byte lane b (bits 8b+7:8b) of word k. A write updates four IDs, and a read returns them. `prio_o` carries ID n in bits 8n+7:8n.
- R8: Targets are one byte per ID starting at 0x800, in the R7 layout, and `target_o` carries them. IDs 0 to 15 are fixed at 0x01, and target writes to those bytes are ignored.
- R9: Words at 0xC00+4k hold 2 trigger bits per ID, with ID 16k+j in bits 2j+1:2j. A write is stored in full. If any bit under mask 0x55555555 is 1 in that write, `cfg_unsup_o` is set, and it stays set until reset.
- R10: Unmapped offsets read zero and ignore writes. Words that cover IDs at or above NUM_LINES read zero and store nothing.
- R11: A pulse on `irq_pulse_i[n]` makes pending bit n 1 after that clock edge. This holds even when a clear-pending write or an acknowledge to the same ID falls in the same cycle.
- R12: An acknowledge strobe clears the pending bit of its ID and sets the active bit. An end-of-interrupt strobe clears the active bit of its ID. If both strobes name the same ID in one cycle, the acknowledge wins.
- R13: `bus_ready_o` pulses in the cycle after each request, and in no other cycle. For reads, `bus_rdata_o` carries the data in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_req_i | input | 1 | Access request, one cycle |
| bus_we_i | input | 1 | 1 for write, 0 for read |
| bus_addr_i | input | 12 | Byte offset |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data |
| bus_ready_o | output | 1 | Access-complete pulse |
| irq_pulse_i | input | NUM_LINES | Peripheral interrupt pulses |
| ack_i | input | 1 | Acknowledge strobe |
| ack_id_i | input | IDW | Acknowledged interrupt ID |
| eoi_i | input | 1 | End-of-interrupt strobe |
| eoi_id_i | input | IDW | Completed interrupt ID |
| dist_en_o | output | 1 | Global distributor enable |
| enable_o | output | NUM_LINES | Per-ID enable |
| pending_o | output | NUM_LINES | Per-ID pending |
| active_o | output | NUM_LINES | Per-ID active |
| prio_o | output | NUM_LINES*8 | Per-ID priority bytes |
| target_o | output | NUM_LINES*8 | Per-ID target bytes |
| trig_cfg_o | output | NUM_LINES*2 | Per-ID trigger setting |
| cfg_unsup_o | output | 1 | Sticky unsupported-mode flag |

## Verification
Two functions can act on the same pending bit in one cycle: a peripheral pulse, and a software clear-pending write or an acknowledge. The bench drives the pulse and the bus clear for ID 40 on the same clock edge. It then expects the pending bit to still be set, both on `pending_o` and through a bus read of the pending word. It also drives an acknowledge together with a pulse for one ID. That interrupt must end up both active and pending again.

// File: rtl/idr_pkg.sv
package idr_pkg;

    typedef enum logic [3:0] {
        RG_NONE,
        RG_CTRL,
        RG_TYPE,
        RG_EN_SET,
        RG_EN_CLR,
        RG_PD_SET,
        RG_PD_CLR,
        RG_ACT,
        RG_PRIO,
        RG_TGT,
        RG_CFG
    } region_e;

    localparam logic [31:0] UNSUP_MASK = 32'h5555_5555;
    localparam int          SW_IRQS    = 16;
    localparam logic [7:0]  FIXED_TGT  = 8'h01;

    function automatic region_e decode_region(input logic [11:2] a);
        region_e r;
        r = RG_NONE;
        if (a[11:10] == 2'b01)       r = RG_PRIO;
        else if (a[11:10] == 2'b10)  r = RG_TGT;
        else if (a[11:8] == 4'hC)    r = RG_CFG;
        else if (a[11:7] == 5'd2)    r = RG_EN_SET;
        else if (a[11:7] == 5'd3)    r = RG_EN_CLR;
        else if (a[11:7] == 5'd4)    r = RG_PD_SET;
        else if (a[11:7] == 5'd5)    r = RG_PD_CLR;
        else if (a[11:7] == 5'd6)    r = RG_ACT;
        else if (a[11:2] == 10'd0)   r = RG_CTRL;
        else if (a[11:2] == 10'd1)   r = RG_TYPE;
        return r;
    endfunction

endpackage

// File: rtl/idr_bit_state.sv
module idr_bit_state
    import idr_pkg::*;
#(
    parameter int NUM_LINES = 64,
    parameter int IDW       = $clog2(NUM_LINES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_i,
    input  region_e              rg_i,
    input  logic [4:0]           widx_i,
    input  logic [31:0]          wdata_i,
    input  logic [NUM_LINES-1:0] pulse_i,
    input  logic                 ack_i,
    input  logic [IDW-1:0]       ack_id_i,
    input  logic                 eoi_i,
    input  logic [IDW-1:0]       eoi_id_i,
    output logic [NUM_LINES-1:0] en_o,
    output logic [NUM_LINES-1:0] pend_o,
    output logic [NUM_LINES-1:0] act_o,
    output logic [31:0]          rd_o
);

    localparam int NW = NUM_LINES / 32;
    localparam logic [NUM_LINES-1:0] SW_PROT = {{(NUM_LINES-SW_IRQS){1'b0}}, {SW_IRQS{1'b1}}};

    typedef struct packed {
        logic [NUM_LINES-1:0] en;
        logic [NUM_LINES-1:0] pend;
        logic [NUM_LINES-1:0] act;
    } bits_t;

    bits_t                st_d, st_q;
    logic [NUM_LINES-1:0] wmask;
    logic [NUM_LINES-1:0] ack_vec;
    logic [NUM_LINES-1:0] eoi_vec;
    logic [NUM_LINES-1:0] rd_src;

    always_comb begin
        wmask   = '0;
        ack_vec = '0;
        eoi_vec = '0;
        for (int w = 0; w < NW; w++) begin
            if (widx_i == 5'(w)) wmask[w*32 +: 32] = wdata_i;
        end
        for (int i = 0; i < NUM_LINES; i++) begin
            if (ack_i && ack_id_i == IDW'(i)) ack_vec[i] = 1'b1;
            if (eoi_i && eoi_id_i == IDW'(i)) eoi_vec[i] = 1'b1;
        end

        st_d = st_q;
        if (wr_i) begin
            case (rg_i)
                RG_EN_SET: st_d.en   = st_q.en | wmask;
                RG_EN_CLR: st_d.en   = st_q.en & ~wmask;
                RG_PD_SET: st_d.pend = st_q.pend | (wmask & ~SW_PROT);
                RG_PD_CLR: st_d.pend = st_q.pend & ~(wmask & ~SW_PROT);
                default: ;
            endcase
        end
        st_d.pend = (st_d.pend & ~ack_vec) | pulse_i;
        st_d.act  = (st_q.act & ~eoi_vec) | ack_vec;

        case (rg_i)
            RG_EN_SET, RG_EN_CLR: rd_src = st_q.en;
            RG_PD_SET, RG_PD_CLR: rd_src = st_q.pend;
            RG_ACT:               rd_src = st_q.act;
            default:              rd_src = '0;
        endcase
        rd_o = '0;
        for (int w = 0; w < NW; w++) begin
            if (widx_i == 5'(w)) rd_o = rd_src[w*32 +: 32];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign en_o   = st_q.en;
    assign pend_o = st_q.pend;
    assign act_o  = st_q.act;

    // R5
    sgi_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && (rg_i == RG_PD_SET || rg_i == RG_PD_CLR) && pulse_i[SW_IRQS-1:0] == '0
         && !(ack_i && ack_id_i < IDW'(SW_IRQS)))
        |=> $stable(pend_o[SW_IRQS-1:0]));

    // R11
    pulse_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|pulse_i) |=> ((pend_o & $past(pulse_i)) == $past(pulse_i)));

    // R12
    ack_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_i |=> act_o[$past(ack_id_i)]);

    // R12
    eoi_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_i && !(ack_i && ack_id_i == eoi_id_i)) |=> !act_o[$past(eoi_id_i)]);

endmodule

// File: rtl/idr_byte_array.sv
module idr_byte_array #(
    parameter int         NUM_LINES  = 64,
    parameter int         LOCK_BELOW = 0,
    parameter logic [7:0] LOCK_VAL   = 8'h00
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_i,
    input  logic                   sel_i,
    input  logic [7:0]             widx_i,
    input  logic [31:0]            wdata_i,
    output logic [NUM_LINES*8-1:0] bytes_o,
    output logic [31:0]            rd_o
);

    localparam int NWORDS = NUM_LINES / 4;

    typedef struct packed {
        logic [NUM_LINES*8-1:0] b;
    } arr_t;

    arr_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NUM_LINES; i++) begin
            if (i >= LOCK_BELOW && wr_i && sel_i && widx_i == 8'(i / 4))
                st_d.b[i*8 +: 8] = wdata_i[(i % 4)*8 +: 8];
        end
        rd_o = '0;
        for (int w = 0; w < NWORDS; w++) begin
            if (sel_i && widx_i == 8'(w)) rd_o = st_q.b[w*32 +: 32];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_LINES; i++)
                st_q.b[i*8 +: 8] <= (i < LOCK_BELOW) ? LOCK_VAL : 8'h00;
        end else begin
            st_q <= st_d;
        end
    end

    assign bytes_o = st_q.b;

    generate
        if (LOCK_BELOW > 0) begin : g_lock
            // R8
            locked_bytes_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_i && sel_i) |=> $stable(bytes_o[LOCK_BELOW*8-1:0]));
        end
    endgenerate

endmodule

// File: rtl/idr_cfg_store.sv
module idr_cfg_store
    import idr_pkg::*;
#(
    parameter int NUM_LINES = 64
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_i,
    input  logic                   sel_i,
    input  logic [5:0]             widx_i,
    input  logic [31:0]            wdata_i,
    output logic [NUM_LINES*2-1:0] cfg_o,
    output logic                   unsup_o,
    output logic [31:0]            rd_o
);

    localparam int NCW = NUM_LINES / 16;

    typedef struct packed {
        logic [NUM_LINES*2-1:0] cfg;
        logic                   unsup;
    } cfg_t;

    cfg_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        rd_o = '0;
        if (wr_i && sel_i) begin
            for (int w = 0; w < NCW; w++) begin
                if (widx_i == 6'(w)) st_d.cfg[w*32 +: 32] = wdata_i;
            end
            if ((wdata_i & UNSUP_MASK) != '0) st_d.unsup = 1'b1;
        end
        for (int w = 0; w < NCW; w++) begin
            if (sel_i && widx_i == 6'(w)) rd_o = st_q.cfg[w*32 +: 32];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cfg_o   = st_q.cfg;
    assign unsup_o = st_q.unsup;

    // R9
    unsup_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && sel_i && (wdata_i & UNSUP_MASK) != '0) |=> unsup_o);

    // R9
    unsup_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        unsup_o |=> unsup_o);

endmodule

// File: rtl/irq_dist_regs.sv
module irq_dist_regs
    import idr_pkg::*;
#(
    parameter int NUM_LINES = 64,
    parameter int NUM_CPUS  = 4,
    parameter int IDW       = $clog2(NUM_LINES)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   bus_req_i,
    input  logic                   bus_we_i,
    input  logic [11:0]            bus_addr_i,
    input  logic [31:0]            bus_wdata_i,
    output logic [31:0]            bus_rdata_o,
    output logic                   bus_ready_o,
    input  logic [NUM_LINES-1:0]   irq_pulse_i,
    input  logic                   ack_i,
    input  logic [IDW-1:0]         ack_id_i,
    input  logic                   eoi_i,
    input  logic [IDW-1:0]         eoi_id_i,
    output logic                   dist_en_o,
    output logic [NUM_LINES-1:0]   enable_o,
    output logic [NUM_LINES-1:0]   pending_o,
    output logic [NUM_LINES-1:0]   active_o,
    output logic [NUM_LINES*8-1:0] prio_o,
    output logic [NUM_LINES*8-1:0] target_o,
    output logic [NUM_LINES*2-1:0] trig_cfg_o,
    output logic                   cfg_unsup_o
);

    localparam logic [31:0] TYPE_WORD = 32'(((NUM_CPUS - 1) << 5) | (NUM_LINES / 32 - 1));

    typedef struct packed {
        logic        en;
        logic        ready;
        logic [31:0] rdata;
    } top_t;

    top_t        st_d, st_q;
    region_e     rg;
    logic        wr;
    logic [31:0] rd_bits, rd_prio, rd_tgt, rd_cfg;
    logic        unused_addr_lsb;

    assign rg              = decode_region(bus_addr_i[11:2]);
    assign wr              = bus_req_i && bus_we_i;
    assign unused_addr_lsb = ^bus_addr_i[1:0];

    idr_bit_state #(.NUM_LINES(NUM_LINES), .IDW(IDW)) bits_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_i     (wr),
        .rg_i     (rg),
        .widx_i   (bus_addr_i[6:2]),
        .wdata_i  (bus_wdata_i),
        .pulse_i  (irq_pulse_i),
        .ack_i    (ack_i),
        .ack_id_i (ack_id_i),
        .eoi_i    (eoi_i),
        .eoi_id_i (eoi_id_i),
        .en_o     (enable_o),
        .pend_o   (pending_o),
        .act_o    (active_o),
        .rd_o     (rd_bits)
    );

    idr_byte_array #(.NUM_LINES(NUM_LINES), .LOCK_BELOW(0), .LOCK_VAL(8'h00)) prio_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (wr),
        .sel_i   (rg == RG_PRIO),
        .widx_i  (bus_addr_i[9:2]),
        .wdata_i (bus_wdata_i),
        .bytes_o (prio_o),
        .rd_o    (rd_prio)
    );

    idr_byte_array #(.NUM_LINES(NUM_LINES), .LOCK_BELOW(SW_IRQS), .LOCK_VAL(FIXED_TGT)) tgt_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (wr),
        .sel_i   (rg == RG_TGT),
        .widx_i  (bus_addr_i[9:2]),
        .wdata_i (bus_wdata_i),
        .bytes_o (target_o),
        .rd_o    (rd_tgt)
    );

    idr_cfg_store #(.NUM_LINES(NUM_LINES)) cfg_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (wr),
        .sel_i   (rg == RG_CFG),
        .widx_i  (bus_addr_i[7:2]),
        .wdata_i (bus_wdata_i),
        .cfg_o   (trig_cfg_o),
        .unsup_o (cfg_unsup_o),
        .rd_o    (rd_cfg)
    );

    always_comb begin
        st_d       = st_q;
        st_d.ready = bus_req_i;
        st_d.rdata = '0;
        if (wr && rg == RG_CTRL) st_d.en = bus_wdata_i[0];
        if (bus_req_i && !bus_we_i) begin
            case (rg)
                RG_CTRL:  st_d.rdata = {31'd0, st_q.en};
                RG_TYPE:  st_d.rdata = TYPE_WORD;
                RG_EN_SET, RG_EN_CLR, RG_PD_SET, RG_PD_CLR, RG_ACT:
                          st_d.rdata = rd_bits;
                RG_PRIO:  st_d.rdata = rd_prio;
                RG_TGT:   st_d.rdata = rd_tgt;
                RG_CFG:   st_d.rdata = rd_cfg;
                default:  st_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dist_en_o   = st_q.en;
    assign bus_ready_o = st_q.ready;
    assign bus_rdata_o = st_q.rdata;

    // R13
    ready_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req_i |=> bus_ready_o);

    // R13
    no_spurious_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_req_i |=> !bus_ready_o);

    // R1
    ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr && rg == RG_CTRL) |=> $stable(dist_en_o));

endmodule

// File: tb/irq_dist_regs_tb_top.sv
module irq_dist_regs_tb_top;

    localparam int NL  = 64;
    localparam int IDW = 6;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_req_i = 1'b0;
    logic              bus_we_i = 1'b0;
    logic [11:0]       bus_addr_i = '0;
    logic [31:0]       bus_wdata_i = '0;
    logic [31:0]       bus_rdata_o;
    logic              bus_ready_o;
    logic [NL-1:0]     irq_pulse_i = '0;
    logic              ack_i = 1'b0;
    logic [IDW-1:0]    ack_id_i = '0;
    logic              eoi_i = 1'b0;
    logic [IDW-1:0]    eoi_id_i = '0;
    logic              dist_en_o;
    logic [NL-1:0]     enable_o, pending_o, active_o;
    logic [NL*8-1:0]   prio_o, target_o;
    logic [NL*2-1:0]   trig_cfg_o;
    logic              cfg_unsup_o;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    irq_dist_regs #(.NUM_LINES(NL), .NUM_CPUS(4)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .bus_req_i(bus_req_i), .bus_we_i(bus_we_i), .bus_addr_i(bus_addr_i),
        .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o), .bus_ready_o(bus_ready_o),
        .irq_pulse_i(irq_pulse_i), .ack_i(ack_i), .ack_id_i(ack_id_i),
        .eoi_i(eoi_i), .eoi_id_i(eoi_id_i), .dist_en_o(dist_en_o),
        .enable_o(enable_o), .pending_o(pending_o), .active_o(active_o),
        .prio_o(prio_o), .target_o(target_o), .trig_cfg_o(trig_cfg_o),
        .cfg_unsup_o(cfg_unsup_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_req_i = 1'b1; bus_we_i = 1'b1; bus_addr_i = a; bus_wdata_i = d;
        @(negedge clk);
        bus_req_i = 1'b0; bus_we_i = 1'b0;
        check("R13 write ready", {31'd0, bus_ready_o}, 32'd1);
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_req_i = 1'b1; bus_we_i = 1'b0; bus_addr_i = a;
        @(negedge clk);
        bus_req_i = 1'b0;
        d = bus_rdata_o;
        if (bus_ready_o !== 1'b1) begin
            checks++; fails++;
            $display("FAIL R13 read ready actual=%0b expected=1", bus_ready_o);
        end
    endtask

    task automatic t_reset();
        logic [31:0] v;
        check("R13 idle ready", {31'd0, bus_ready_o}, 32'd0);
        check("R4 reset pending", pending_o[31:0], 32'd0);
        check("R8 reset fixed target id0", {24'd0, target_o[7:0]}, 32'h01);
        bus_read(12'h000, v); check("R1 reset ctrl", v, 32'd0);
        bus_read(12'h004, v); check("R2 type word", v, 32'h61);
    endtask

    task automatic t_ctrl();
        logic [31:0] v;
        bus_write(12'h000, 32'hFFFF_FFFF);
        check("R1 enable out", {31'd0, dist_en_o}, 32'd1);
        bus_read(12'h000, v); check("R1 ctrl read", v, 32'd1);
    endtask

    task automatic t_enable();
        logic [31:0] v;
        bus_write(12'h104, 32'hF0F0_0001);
        bus_write(12'h104, 32'h0000_0000);
        check("R3 set word1", enable_o[63:32], 32'hF0F0_0001);
        bus_write(12'h184, 32'h00F0_0001);
        check("R3 clear word1", enable_o[63:32], 32'hF000_0000);
        bus_read(12'h104, v); check("R3 read set window", v, 32'hF000_0000);
        bus_read(12'h184, v); check("R3 read clear window", v, 32'hF000_0000);
        check("R3 word0 untouched", enable_o[31:0], 32'd0);
    endtask

    task automatic t_pending();
        logic [31:0] v;
        bus_write(12'h200, 32'hFFFF_FFFF);
        check("R5 set guards low ids", pending_o[31:0], 32'hFFFF_0000);
        bus_write(12'h280, 32'hFFFF_FFFF);
        check("R4 clear word0", pending_o[31:0], 32'h0000_0000);
        bus_write(12'h204, 32'h0000_00A5);
        bus_read(12'h284, v); check("R4 read clear window", v, 32'h0000_00A5);
        bus_write(12'h284, 32'h0000_00A5);
        check("R4 clear word1", pending_o[63:32], 32'd0);
    endtask

    task automatic t_sgi_guard();
        logic [31:0] v;
        @(negedge clk);
        irq_pulse_i = NL'(64'h0000_0000_0000_0008);
        @(negedge clk);
        irq_pulse_i = '0;
        bus_write(12'h280, 32'h0000_FFFF);
        bus_read(12'h200, v); check("R5 clear cannot drop id3", v, 32'h0000_0008);
        @(negedge clk); ack_i = 1'b1; ack_id_i = 6'd3;
        @(negedge clk); ack_i = 1'b0;
        @(negedge clk); eoi_i = 1'b1; eoi_id_i = 6'd3;
        @(negedge clk); eoi_i = 1'b0;
    endtask

    task automatic t_pulse_vs_clear();
        logic [31:0] v;
        @(negedge clk);
        irq_pulse_i[40] = 1'b1;
        bus_req_i = 1'b1; bus_we_i = 1'b1; bus_addr_i = 12'h284; bus_wdata_i = 32'h0000_0100;
        @(negedge clk);
        irq_pulse_i = '0; bus_req_i = 1'b0; bus_we_i = 1'b0;
        check("R11 pulse beats clear", {31'd0, pending_o[40]}, 32'd1);
        bus_read(12'h204, v); check("R11 pending word read", v, 32'h0000_0100);
        @(negedge clk); irq_pulse_i[50] = 1'b1;
        @(negedge clk); irq_pulse_i = '0;
        check("R11 lone pulse", {31'd0, pending_o[50]}, 32'd1);
    endtask

    task automatic t_ack_eoi();
        logic [31:0] v;
        @(negedge clk); ack_i = 1'b1; ack_id_i = 6'd40;
        @(negedge clk); ack_i = 1'b0;
        check("R12 ack clears pending", {31'd0, pending_o[40]}, 32'd0);
        check("R12 ack sets active", {31'd0, active_o[40]}, 32'd1);
        bus_read(12'h304, v); check("R6 active read", v, 32'h0000_0100);
        @(negedge clk); eoi_i = 1'b1; eoi_id_i = 6'd40;
        @(negedge clk); eoi_i = 1'b0;
        check("R12 eoi clears active", {31'd0, active_o[40]}, 32'd0);
        @(negedge clk); ack_i = 1'b1; ack_id_i = 6'd50; irq_pulse_i[50] = 1'b1;
        @(negedge clk); ack_i = 1'b0; irq_pulse_i = '0;
        check("R11 pulse beats ack", {31'd0, pending_o[50]}, 32'd1);
        check("R12 ack with pulse active", {31'd0, active_o[50]}, 32'd1);
        @(negedge clk); ack_i = 1'b1; ack_id_i = 6'd50; eoi_i = 1'b1; eoi_id_i = 6'd50;
        @(negedge clk); ack_i = 1'b0; eoi_i = 1'b0;
        check("R12 ack wins over eoi", {31'd0, active_o[50]}, 32'd1);
    endtask

    task automatic t_prio();
        logic [31:0] v;
        bus_write(12'h404, 32'h4433_2211);
        check("R7 lane packing", prio_o[32 +: 32], 32'h4433_2211);
        check("R7 id5 byte", {24'd0, prio_o[40 +: 8]}, 32'h22);
        bus_read(12'h404, v); check("R7 read back", v, 32'h4433_2211);
    endtask

    task automatic t_target();
        logic [31:0] v;
        bus_write(12'h800, 32'hFFFF_FFFF);
        bus_write(12'h83C, 32'hFFFF_FFFF);
        check("R8 low ids locked", target_o[127:96], 32'h0101_0101);
        bus_read(12'h800, v); check("R8 read locked word", v, 32'h0101_0101);
        bus_write(12'h810, 32'h0804_0201);
        check("R8 id16-19 written", target_o[128 +: 32], 32'h0804_0201);
    endtask

    task automatic t_cfg();
        logic [31:0] v;
        bus_write(12'hC04, 32'hAAAA_AAAA);
        check("R9 no flag on supported", {31'd0, cfg_unsup_o}, 32'd0);
        bus_read(12'hC04, v); check("R9 read cfg", v, 32'hAAAA_AAAA);
        check("R9 cfg port", trig_cfg_o[32 +: 32], 32'hAAAA_AAAA);
        bus_write(12'hC08, 32'h0000_0004);
        check("R9 flag set", {31'd0, cfg_unsup_o}, 32'd1);
        bus_write(12'hC08, 32'h0000_0000);
        check("R9 flag sticky", {31'd0, cfg_unsup_o}, 32'd1);
        bus_read(12'hC08, v); check("R9 full value stored", v, 32'h0000_0000);
    endtask

    task automatic t_unmapped();
        logic [31:0] v;
        bus_write(12'hF00, 32'hFFFF_FFFF);
        bus_read(12'hF00, v); check("R10 unmapped read", v, 32'd0);
        bus_write(12'h108, 32'hFFFF_FFFF);
        check("R10 out-of-range enable", enable_o[63:32], 32'hF000_0000);
        bus_read(12'h108, v); check("R10 out-of-range enable read", v, 32'd0);
        bus_write(12'h440, 32'h1234_5678);
        bus_read(12'h440, v); check("R10 out-of-range prio", v, 32'd0);
        check("R10 ctrl untouched", {31'd0, dist_en_o}, 32'd1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL R13 watchdog actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ctrl();
        t_enable();
        t_pending();
        t_sgi_guard();
        t_pulse_vs_clear();
        t_ack_eoi();
        t_prio();
        t_target();
        t_cfg();
        t_unmapped();
        repeat (2) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule